// File: doc/BRIEF.md
# Masked Sliding Frame Header Detector

This block watches a serial bit stream, one bit per clock enable, and reports every position at which the most recent bits form a programmed frame header. Each accepted bit moves into a 32-bit history. After every accepted bit, that history is compared with a 32-bit header pattern. A per-bit don't-care mask applies to the comparison, so a header can be made shorter than the full length or can contain gaps. A mode input selects one of two header lengths. In the long mode all 32 bits take part. In the short mode only the ten most recent bits take part.

The pattern and the mask are each held as four byte lanes. A one-byte write port with a lane index loads them. After reset the pattern holds the middle of the standard SDH/SONET framing sequence (the last two A1 bytes, then the first two A2 bytes), and the mask is clear. A deserializer downstream uses the one-cycle match pulse to align its word boundaries.

Top module: `frame_hdr_detect`

## Requirements
- R1: While rst_n is low, match_o is low and the history and bit count are cleared. Release of rst_n is resynchronised, so the bits offered on the first two rising edges after rst_n rises are not accepted.
- R2: After reset the pattern is 32'hF6F62828 and the mask is all zeros. A reset in mid-stream restores both values.
- R3: A mask bit of 1 makes the matching pattern bit don't-care. A match needs equality at every position whose mask bit is 0.
- R4: In long mode (short_mode = 0), the earliest of the 32 most recent accepted bits is compared with pattern bit 31 and the newest with bit 0. The same header sent in the reverse bit order does not match.
- R5: In short mode (short_mode = 1), only pattern and mask bits 9:0 are used, against the 10 most recent bits with the newest at bit 0. Pattern bits 31:10 have no effect on the result.
- R6: No match is reported until, since reset, 32 bits (long mode) or 10 bits (short mode) have been accepted.
- R7: A bit is accepted on a rising edge where bit_en = 1. When the comparison after that bit succeeds, match_o goes high on the following rising edge and stays high for exactly one cycle. Edges with bit_en = 0 neither shift the history nor produce a pulse.
- R8: When pat_we (or msk_we) is 1 on a rising edge, wr_data is written into byte lane wr_idx of the pattern (or mask). Lane k holds bits 8k+7 down to 8k. The write is used from the next edge on, and the other lanes keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, release resynchronised |
| bit_en | input | 1 | Serial bit valid; bit_in is accepted on this edge |
| bit_in | input | 1 | Serial data bit |
| short_mode | input | 1 | 0: 32-bit header, 1: 10-bit header |
| pat_we | input | 1 | Write enable for a pattern byte lane |
| msk_we | input | 1 | Write enable for a mask byte lane |
| wr_idx | input | 2 | Byte lane selected for a write (lane k = bits 8k+7:8k) |
| wr_data | input | 8 | Byte value to write |
| match_o | output | 1 | One-cycle header match pulse |

## Verification
A bit accepted on rising edge k produces its result on match_o at edge k+1. The bench drives and samples at falling edges and keeps a two-stage queue of expected results, so each value is compared exactly two falling edges after its bit was driven. Pattern, mask and mode are changed only after idle steps have drained that queue, so no pending result depends on a half-applied setting. After rst_n rises, the first offered bit is expected to be dropped, because the second edge is still held in reset by the synchroniser.

// File: rtl/fhd_pkg.sv
`timescale 1ns/100ps
package fhd_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic {
    HDR_LONG  = 1'b0,
    HDR_SHORT = 1'b1
  } hdr_len_e;

  // Tail of the A1 run followed by the head of the A2 run.
  localparam logic [31:0] SDH_DEFAULT_HDR = 32'hF6F6_2828;
endpackage

// File: rtl/fhd_rst_sync.sv
`timescale 1ns/100ps
module fhd_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/fhd_hdr_regs.sv
`timescale 1ns/100ps
module fhd_hdr_regs #(
  parameter int unsigned HDR_W   = 32,
  parameter int unsigned BYTE_W  = 8,
  parameter int unsigned IDX_W   = 2,
  parameter logic [HDR_W-1:0] DEF_PAT = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pat_we,
  input  logic              msk_we,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [HDR_W-1:0]  pat_o,
  output logic [HDR_W-1:0]  msk_o
);
  localparam int unsigned N_LANES = HDR_W / BYTE_W;

  for (genvar g = 0; g < N_LANES; g++) begin : g_lane
    logic              sel;
    logic              pat_en;
    logic              msk_en;
    logic [BYTE_W-1:0] pat_d;
    logic [BYTE_W-1:0] msk_d;
    logic [BYTE_W-1:0] pat_q;
    logic [BYTE_W-1:0] msk_q;

    always_comb begin
      sel    = (wr_idx == IDX_W'(g));
      pat_en = pat_we & sel;
      msk_en = msk_we & sel;
      pat_d  = wr_data;
      msk_d  = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pat_q <= DEF_PAT[g*BYTE_W +: BYTE_W];
      end else if (pat_en) begin
        pat_q <= pat_d;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        msk_q <= '0;
      end else if (msk_en) begin
        msk_q <= msk_d;
      end
    end

    assign pat_o[g*BYTE_W +: BYTE_W] = pat_q;
    assign msk_o[g*BYTE_W +: BYTE_W] = msk_q;
  end
endmodule

// File: rtl/fhd_history.sv
`timescale 1ns/100ps
module fhd_history #(
  parameter int unsigned HDR_W = 32,
  parameter int unsigned CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_en,
  input  logic             bit_in,
  output logic [HDR_W-1:0] hist_o,
  output logic [CNT_W-1:0] fill_o,
  output logic             fresh_o
);
  logic [HDR_W-1:0] hist_q;
  logic [HDR_W-1:0] hist_d;
  logic [CNT_W-1:0] fill_q;
  logic [CNT_W-1:0] fill_d;
  logic             fill_full;
  logic             fresh_q;

  always_comb begin
    hist_d    = {hist_q[HDR_W-2:0], bit_in};
    fill_full = (fill_q == CNT_W'(HDR_W));
    fill_d    = fill_full ? fill_q : fill_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q <= '0;
      fill_q <= '0;
    end else if (bit_en) begin
      hist_q <= hist_d;
      fill_q <= fill_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fresh_q <= 1'b0;
    end else begin
      fresh_q <= bit_en;
    end
  end

  assign hist_o  = hist_q;
  assign fill_o  = fill_q;
  assign fresh_o = fresh_q;
endmodule

// File: rtl/fhd_compare.sv
`timescale 1ns/100ps
module fhd_compare
  import fhd_pkg::*;
#(
  parameter int unsigned HDR_W   = 32,
  parameter int unsigned SHORT_W = 10,
  parameter int unsigned CNT_W   = 6
) (
  input  logic [HDR_W-1:0] hist,
  input  logic [HDR_W-1:0] pat,
  input  logic [HDR_W-1:0] msk,
  input  logic [CNT_W-1:0] fill,
  input  logic             short_mode,
  output logic             hit
);
  logic [HDR_W-1:0] agree;
  logic             long_ok;
  logic             short_ok;
  hdr_len_e         len_sel;

  for (genvar g = 0; g < HDR_W; g++) begin : g_bit
    assign agree[g] = msk[g] | ~(hist[g] ^ pat[g]);
  end

  always_comb begin
    len_sel  = hdr_len_e'(short_mode);
    long_ok  = (&agree) & (fill >= CNT_W'(HDR_W));
    short_ok = (&agree[SHORT_W-1:0]) & (fill >= CNT_W'(SHORT_W));
    hit      = (len_sel == HDR_SHORT) ? short_ok : long_ok;
  end
endmodule

// File: rtl/frame_hdr_detect.sv
`timescale 1ns/100ps
module frame_hdr_detect
  import fhd_pkg::*;
#(
  parameter int unsigned HDR_W   = 32,
  parameter int unsigned SHORT_W = 10,
  parameter logic [HDR_W-1:0] DEF_PAT = SDH_DEFAULT_HDR,
  localparam int unsigned N_LANES = HDR_W / BYTE_W,
  localparam int unsigned IDX_W   = (N_LANES > 1) ? $clog2(N_LANES) : 1,
  localparam int unsigned CNT_W   = $clog2(HDR_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_en,
  input  logic              bit_in,
  input  logic              short_mode,
  input  logic              pat_we,
  input  logic              msk_we,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [BYTE_W-1:0] wr_data,
  output logic              match_o
);
  logic             rst_sync_n;
  logic [HDR_W-1:0] pat_q;
  logic [HDR_W-1:0] msk_q;
  logic [HDR_W-1:0] hist;
  logic [CNT_W-1:0] fill;
  logic             fresh;
  logic             hit;
  logic             match_d;
  logic             match_q;

  fhd_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  fhd_hdr_regs #(
    .HDR_W   (HDR_W),
    .BYTE_W  (BYTE_W),
    .IDX_W   (IDX_W),
    .DEF_PAT (DEF_PAT)
  ) u_regs (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .pat_we  (pat_we),
    .msk_we  (msk_we),
    .wr_idx  (wr_idx),
    .wr_data (wr_data),
    .pat_o   (pat_q),
    .msk_o   (msk_q)
  );

  fhd_history #(
    .HDR_W (HDR_W),
    .CNT_W (CNT_W)
  ) u_hist (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .bit_en  (bit_en),
    .bit_in  (bit_in),
    .hist_o  (hist),
    .fill_o  (fill),
    .fresh_o (fresh)
  );

  fhd_compare #(
    .HDR_W   (HDR_W),
    .SHORT_W (SHORT_W),
    .CNT_W   (CNT_W)
  ) u_cmp (
    .hist       (hist),
    .pat        (pat_q),
    .msk        (msk_q),
    .fill       (fill),
    .short_mode (short_mode),
    .hit        (hit)
  );

  always_comb begin
    match_d = fresh & hit;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      match_q <= 1'b0;
    end else begin
      match_q <= match_d;
    end
  end

  assign match_o = match_q;
endmodule

// File: rtl/fhd_checker.sv
`timescale 1ns/100ps
module fhd_checker #(
  parameter int unsigned HDR_W   = 32,
  parameter int unsigned SHORT_W = 10,
  parameter int unsigned CNT_W   = 6,
  parameter logic [HDR_W-1:0] DEF_PAT = '0
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rst_sync_n,
  input logic             bit_en,
  input logic             bit_in,
  input logic             short_mode,
  input logic [HDR_W-1:0] pat,
  input logic [HDR_W-1:0] msk,
  input logic             match_o
);
  localparam logic [HDR_W-1:0] SHORT_SEL = HDR_W'((64'd1 << SHORT_W) - 64'd1);

  logic [HDR_W-1:0] ck_hist;
  logic [CNT_W-1:0] ck_cnt;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      ck_hist <= '0;
      ck_cnt  <= '0;
    end else if (bit_en) begin
      ck_hist <= {ck_hist[HDR_W-2:0], bit_in};
      if (ck_cnt != CNT_W'(HDR_W)) begin
        ck_cnt <= ck_cnt + CNT_W'(1);
      end
    end
  end

  // R1: output held low while the reset input is active
  always @(posedge clk) begin
    if (!rst_n) begin
      a_r1_quiet_in_reset: assert (!match_o);
    end
  end

  // R2: defaults present when the internal reset lifts
  a_r2_defaults: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_sync_n) |-> (pat == DEF_PAT) && (msk == '0));

  // R3: every unmasked position in use agreed with the bit history
  a_r3_unmasked_equal: assert property (@(posedge clk) disable iff (!rst_sync_n)
    match_o |-> ((($past(ck_hist) ^ $past(pat)) & ~$past(msk)
                  & ($past(short_mode) ? SHORT_SEL : '1)) == '0));

  // R6: enough bits accepted for the selected length
  a_r6_short_fill: assert property (@(posedge clk) disable iff (!rst_sync_n)
    match_o |-> ($past(ck_cnt) >= CNT_W'(SHORT_W)));

  a_r6_long_fill: assert property (@(posedge clk) disable iff (!rst_sync_n)
    match_o && !$past(short_mode) |-> ($past(ck_cnt) >= CNT_W'(HDR_W)));

  // R7: a pulse always follows an accepted bit two edges earlier
  a_r7_needs_bit: assert property (@(posedge clk) disable iff (!rst_sync_n)
    match_o |-> $past(bit_en, 2));

  // R7: without a new bit the pulse lasts a single cycle
  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_sync_n)
    match_o && !$past(bit_en) |=> !match_o);
endmodule

bind frame_hdr_detect fhd_checker #(
  .HDR_W   (HDR_W),
  .SHORT_W (SHORT_W),
  .CNT_W   (CNT_W),
  .DEF_PAT (DEF_PAT)
) u_fhd_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rst_sync_n (rst_sync_n),
  .bit_en     (bit_en),
  .bit_in     (bit_in),
  .short_mode (short_mode),
  .pat        (pat_q),
  .msk        (msk_q),
  .match_o    (match_o)
);

// File: tb/tb_frame_hdr_detect.sv
`timescale 1ns/100ps
module tb_frame_hdr_detect;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bit_en = 1'b0;
  logic       bit_in = 1'b0;
  logic       short_mode = 1'b0;
  logic       pat_we = 1'b0;
  logic       msk_we = 1'b0;
  logic [1:0] wr_idx = 2'd0;
  logic [7:0] wr_data = 8'd0;
  logic       match_o;

  frame_hdr_detect dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .bit_en     (bit_en),
    .bit_in     (bit_in),
    .short_mode (short_mode),
    .pat_we     (pat_we),
    .msk_we     (msk_we),
    .wr_idx     (wr_idx),
    .wr_data    (wr_data),
    .match_o    (match_o)
  );

  always #2.5 clk = ~clk;

  int          n_chk = 0;
  int          n_fail = 0;
  string       cur_tag = "R1";
  logic [31:0] m_hist = '0;
  int          m_cnt = 0;
  logic [31:0] m_pat = 32'hF6F62828;
  logic [31:0] m_msk = '0;
  logic        e0 = 1'b0;
  logic        e1 = 1'b0;
  int          drop = 0;
  logic [15:0] lfsr = 16'hACE1;
  bit          done = 1'b0;

  task automatic chk(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: match_o actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic m_hit();
    int len = short_mode ? 10 : 32;
    if (m_cnt < len) return 1'b0;
    for (int i = 0; i < len; i++) begin
      if (!m_msk[i] && (m_hist[i] != m_pat[i])) return 1'b0;
    end
    return 1'b1;
  endfunction

  task automatic step(input logic b, input logic en);
    @(negedge clk);
    chk(cur_tag, match_o, e1);
    e1 = e0;
    if (drop > 0) begin
      drop--;
      e0 = 1'b0;
    end else if (en) begin
      m_hist = {m_hist[30:0], b};
      if (m_cnt < 32) m_cnt++;
      e0 = m_hit();
    end else begin
      e0 = 1'b0;
    end
    bit_in = b;
    bit_en = en;
  endtask

  task automatic flush();
    repeat (3) step(1'b0, 1'b0);
  endtask

  task automatic wr(input logic is_msk, input int idx, input logic [7:0] d);
    pat_we  = !is_msk;
    msk_we  = is_msk;
    wr_idx  = idx[1:0];
    wr_data = d;
    if (is_msk) m_msk[idx*8 +: 8] = d;
    else        m_pat[idx*8 +: 8] = d;
    step(1'b0, 1'b0);
    pat_we = 1'b0;
    msk_we = 1'b0;
  endtask

  task automatic send_word(input logic [31:0] w, input int nbits);
    for (int i = nbits - 1; i >= 0; i--) step(w[i], 1'b1);
  endtask

  task automatic send_noise(input int n);
    for (int i = 0; i < n; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[0], 1'b1);
    end
  endtask

  task automatic do_reset(input int idle);
    @(negedge clk);
    rst_n = 1'b0;
    bit_en = 1'b0;
    bit_in = 1'b0;
    pat_we = 1'b0;
    msk_we = 1'b0;
    m_hist = '0;
    m_cnt = 0;
    m_pat = 32'hF6F62828;
    m_msk = '0;
    e0 = 1'b0;
    e1 = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1", match_o, 1'b0);
    rst_n = 1'b1;
    drop = 1;
    repeat (idle) step(1'b0, 1'b0);
  endtask

  // R1: reset state and the bit dropped while the synchroniser releases
  task automatic t_reset();
    cur_tag = "R1";
    @(negedge clk);
    chk("R1", match_o, 1'b0);
    do_reset(0);
    send_word(32'hF6F62828, 32);
    step(1'b0, 1'b0);
    step(1'b0, 1'b0);
    chk("R1", match_o, 1'b0);
    flush();
  endtask

  // R2, R4: default header, and its bit-reversed form
  task automatic t_default();
    do_reset(3);
    cur_tag = "R2";
    send_noise(20);
    send_word(32'hF6F62828, 32);
    step(1'b0, 1'b0);
    step(1'b0, 1'b0);
    chk("R2", match_o, 1'b1);
    step(1'b0, 1'b0);
    chk("R7", match_o, 1'b0);
    cur_tag = "R4";
    send_word(32'h14146F6F, 32);
    send_noise(40);
    flush();
  endtask

  // R3: gapped header under a mask
  task automatic t_mask();
    cur_tag = "R3";
    flush();
    wr(1'b0, 0, 8'hF0); wr(1'b0, 1, 8'h0F);
    wr(1'b0, 2, 8'h5A); wr(1'b0, 3, 8'h3C);
    wr(1'b1, 0, 8'h0F); wr(1'b1, 1, 8'hFF);
    send_noise(60);
    send_word(32'h3C5AF0F0 ^ 32'h0000FF0F, 32);
    send_noise(10);
    send_word(32'h3C5A0FF0 ^ 32'h00100000, 32);
    send_noise(10);
    send_word(32'h3C5A33F5, 32);
    step(1'b0, 1'b0);
    step(1'b0, 1'b0);
    chk("R3", match_o, 1'b1);
    flush();
  endtask

  // R5: short header, upper pattern bits irrelevant
  task automatic t_short();
    cur_tag = "R5";
    flush();
    short_mode = 1'b1;
    wr(1'b0, 0, 8'b0110_1101); wr(1'b0, 1, 8'hFE);
    wr(1'b0, 2, 8'h00); wr(1'b0, 3, 8'h81);
    wr(1'b1, 0, 8'h08); wr(1'b1, 1, 8'h00);
    send_noise(30);
    send_word(32'h0000026D, 10);
    send_word(32'h00000265, 10);
    step(1'b0, 1'b0);
    step(1'b0, 1'b0);
    chk("R5", match_o, 1'b1);
    send_word(32'h0000016D, 10);
    send_noise(60);
    flush();
    short_mode = 1'b0;
  endtask

  // R6: fill rule in both lengths with everything masked off
  task automatic t_fill();
    cur_tag = "R6";
    do_reset(3);
    short_mode = 1'b1;
    for (int k = 0; k < 4; k++) wr(1'b1, k, 8'hFF);
    send_noise(14);
    flush();
    do_reset(3);
    short_mode = 1'b0;
    for (int k = 0; k < 4; k++) wr(1'b1, k, 8'hFF);
    send_noise(31);
    step(1'b0, 1'b0);
    step(1'b0, 1'b0);
    chk("R6", match_o, 1'b0);
    send_noise(3);
    flush();
  endtask

  // R7: gaps between bits neither shift nor pulse
  task automatic t_gap();
    logic [31:0] w;
    cur_tag = "R7";
    do_reset(3);
    w = 32'hF6F62828;
    send_noise(8);
    for (int i = 31; i >= 0; i--) begin
      step(w[i], 1'b1);
      step(1'b1, 1'b0);
      if (i % 3 == 0) step(1'b0, 1'b0);
    end
    step(1'b0, 1'b0);
    chk("R7", match_o, 1'b0);
    flush();
  endtask

  // R8: single-lane writes, other lanes untouched
  task automatic t_write();
    cur_tag = "R8";
    do_reset(3);
    wr(1'b0, 2, 8'h00);
    send_word(32'hF6F62828, 32);
    send_word(32'hF6002828, 32);
    step(1'b0, 1'b0);
    step(1'b0, 1'b0);
    chk("R8", match_o, 1'b1);
    wr(1'b1, 3, 8'hFF);
    send_word(32'h11002828, 32);
    send_word(32'h11002829, 32);
    flush();
    cur_tag = "R2";
    do_reset(3);
    send_word(32'hF6F62828, 32);
    step(1'b0, 1'b0);
    step(1'b0, 1'b0);
    chk("R2", match_o, 1'b1);
    flush();
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      report();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_default();
    t_mask();
    t_short();
    t_fill();
    t_gap();
    t_write();
    done = 1'b1;
    report();
  end
endmodule